// File: doc/BRIEF.md
# Clock Stop Gating Controller

This block sits between a set of free-running internal clock sources and the clock outputs of a clock generator. It produces gated copies of six clock groups: a processor group, a 66 MHz-class group, a stoppable bus group, a free-running bus clock, a reference group and an interrupt-controller group. Three active-low requests control the gating, and any of them may change at any moment. A processor-stop request silences the processor and 66 MHz groups. A bus-stop request silences the stoppable bus group. A power-down request silences every group and drops the oscillator and PLL enables.

Each request is synchronized separately into every clock domain it touches. A latch that is open only while the source clock is low then closes the gate. Outputs therefore start and stop on whole cycles, and an idle output rests LOW. When power-down is released, a settle counter in the reference domain holds every output LOW for a parameterized number of reference cycles, which stands in for oscillator and PLL start-up. The oscillator enable comes up before the PLL enable.

Top module: `clkstop_ctrl`

## Requirements
- R1: While pwrdn_n is 0 (power down), no clock output pulses and osc_en and pll_en are 0, whatever cpu_stop_n and pci_stop_n are.
- R2: With power up and cpu_stop_n at 0, cpu_clk_o and mid_clk_o stay LOW. pcif_clk_o, ref_clk_o and apic_clk_o keep pulsing, and pci_clk_o depends only on pci_stop_n.
- R3: While pci_stop_n is 0, pci_clk_o stays LOW and pcif_clk_o keeps pulsing. When pci_stop_n falls 1 ns after a clk_pci rising edge, pci_clk_o gives exactly two more pulses.
- R4: With pwrdn_n at 1 and the exit sequence complete, osc_en and pll_en are both 1 for all four combinations of the stop inputs.
- R5: When cpu_stop_n falls 1 ns after a clk_cpu rising edge, cpu_clk_o pulses on the next two rising edges only. When it rises 1 ns after an edge, the first pulse comes on the third rising edge.
- R6: Every pulse on a gated output spans a whole high phase of its source clock. The output is LOW throughout every low phase of that clock, so a stopped output rests LOW.
- R7: mid_clk_o follows cpu_stop_n through its own clk_mid synchronizer. After cpu_stop_n falls 1 ns past a clk_mid rising edge, exactly two pulses occur within three clk_mid cycles and none after.
- R8: After pwrdn_n rises 1 ns past a clk_ref rising edge, no output pulses up to and including clk_ref edge SETTLE_CYC+3. ref_clk_o stays LOW through edge SETTLE_CYC+5 and pulses on edge SETTLE_CYC+6. After that every group runs.
- R9: After pwrdn_n rises 1 ns past a clk_ref edge, osc_en becomes 1 after the third clk_ref edge and pll_en after the fourth. After a fall, both enables are still 1 after the second edge and both are 0 after the third. pll_en is never 1 while osc_en is 0.
- R10: While rst is 1, no output pulses and osc_en and pll_en are 0.
- R11: All copies within one output group carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Free-running processor-group source clock |
| clk_mid | input | 1 | Free-running 66 MHz-group source clock |
| clk_pci | input | 1 | Free-running bus source clock (stoppable and free-running groups) |
| clk_ref | input | 1 | Free-running reference clock; also clocks the settle counter |
| clk_apic | input | 1 | Free-running interrupt-controller source clock |
| rst | input | 1 | Synchronous active-high reset, sampled in every domain |
| cpu_stop_n | input | 1 | Asynchronous, active low: stop processor and 66 MHz groups |
| pci_stop_n | input | 1 | Asynchronous, active low: stop the stoppable bus group |
| pwrdn_n | input | 1 | Asynchronous, active low: power down everything |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| mid_clk_o | output | N_MID | Gated 66 MHz clocks |
| pci_clk_o | output | N_PCI | Gated stoppable bus clocks |
| pcif_clk_o | output | 1 | Bus clock gated only by power down |
| ref_clk_o | output | N_REF | Gated reference clocks |
| apic_clk_o | output | N_APIC | Gated interrupt-controller clocks |
| osc_en | output | 1 | Oscillator enable, registered in the reference domain |
| pll_en | output | 1 | PLL enable, registered, rises one reference cycle after osc_en |

## Verification
The checker asserts the following on every cycle. A group is parked LOW once its stop request has been held for three of its own cycles. pll_en never leads osc_en. Readiness implies both enables. Readiness is cleared whenever the oscillator enable falls. The settle interval has elapsed before readiness rises. The bench's scenarios show the rest: the exact two-pulse stop and third-edge start latency, whole-phase pulses under random asynchronous request edges, the exact power-up timeline of the enables and the first reference pulse, and the group-by-group run/stop map over every combination of the three requests.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [2:0] {
    DOM_CPU  = 3'd0,
    DOM_MID  = 3'd1,
    DOM_PCI  = 3'd2,
    DOM_PCIF = 3'd3,
    DOM_REF  = 3'd4,
    DOM_APIC = 3'd5
  } dom_e;

  localparam int unsigned NUM_DOM    = 6;
  localparam int unsigned SYNC_DEPTH = 2;

  // Domains silenced by the processor-stop request.
  function automatic logic dom_uses_cpu_stop(input int d);
    return (d == int'(DOM_CPU)) || (d == int'(DOM_MID));
  endfunction

  // Domains silenced by the bus-stop request (the free-running bus clock is exempt).
  function automatic logic dom_uses_pci_stop(input int d);
    return (d == int'(DOM_PCI));
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_gate.sv
module cg_gate #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_async,
  output logic gclk
);
  logic run_s;
  logic en_l;

  cg_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (run_async),
    .q   (run_s)
  );

  // Enable may only move while the source clock is low: no shortened phase.
  always_latch begin
    if (!clk) en_l <= run_s;
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/cg_settle.sv
module cg_settle #(
  parameter int unsigned SETTLE_CYC = 32,
  parameter int unsigned STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok_async,
  output logic osc_en,
  output logic pll_en,
  output logic ready
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic          pwr_s;
  logic [CW-1:0] cnt;

  cg_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_ok_async),
    .q   (pwr_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en <= 1'b0;
      pll_en <= 1'b0;
      ready  <= 1'b0;
      cnt    <= '0;
    end else begin
      osc_en <= pwr_s;
      pll_en <= pwr_s & osc_en;
      if (!pwr_s) begin
        cnt   <= '0;
        ready <= 1'b0;
      end else if (cnt == CW'(SETTLE_CYC)) begin
        ready <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int unsigned N_CPU       = 6,
  parameter int unsigned N_MID       = 2,
  parameter int unsigned N_PCI       = 5,
  parameter int unsigned N_REF       = 2,
  parameter int unsigned N_APIC      = 3,
  parameter int unsigned SETTLE_CYC  = 32,
  parameter int unsigned SYNC_STAGES = cg_pkg::SYNC_DEPTH
) (
  input  logic              clk_cpu,
  input  logic              clk_mid,
  input  logic              clk_pci,
  input  logic              clk_ref,
  input  logic              clk_apic,
  input  logic              rst,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pwrdn_n,
  output logic [N_CPU-1:0]  cpu_clk_o,
  output logic [N_MID-1:0]  mid_clk_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic              pcif_clk_o,
  output logic [N_REF-1:0]  ref_clk_o,
  output logic [N_APIC-1:0] apic_clk_o,
  output logic              osc_en,
  output logic              pll_en
);
  import cg_pkg::*;

  logic               ready;
  logic [NUM_DOM-1:0] dom_clk;
  logic [NUM_DOM-1:0] dom_run;
  logic [NUM_DOM-1:0] dom_gclk;

  cg_settle #(.SETTLE_CYC(SETTLE_CYC), .STAGES(SYNC_STAGES)) u_settle (
    .clk          (clk_ref),
    .rst          (rst),
    .pwr_ok_async (pwrdn_n),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .ready        (ready)
  );

  assign dom_clk[DOM_CPU]  = clk_cpu;
  assign dom_clk[DOM_MID]  = clk_mid;
  assign dom_clk[DOM_PCI]  = clk_pci;
  assign dom_clk[DOM_PCIF] = clk_pci;
  assign dom_clk[DOM_REF]  = clk_ref;
  assign dom_clk[DOM_APIC] = clk_apic;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam logic USE_CPU = dom_uses_cpu_stop(d);
    localparam logic USE_PCI = dom_uses_pci_stop(d);

    assign dom_run[d] = ready & (cpu_stop_n | ~USE_CPU) & (pci_stop_n | ~USE_PCI);

    cg_gate #(.STAGES(SYNC_STAGES)) u_gate (
      .clk       (dom_clk[d]),
      .rst       (rst),
      .run_async (dom_run[d]),
      .gclk      (dom_gclk[d])
    );
  end

  assign cpu_clk_o  = {N_CPU{dom_gclk[DOM_CPU]}};
  assign mid_clk_o  = {N_MID{dom_gclk[DOM_MID]}};
  assign pci_clk_o  = {N_PCI{dom_gclk[DOM_PCI]}};
  assign pcif_clk_o = dom_gclk[DOM_PCIF];
  assign ref_clk_o  = {N_REF{dom_gclk[DOM_REF]}};
  assign apic_clk_o = {N_APIC{dom_gclk[DOM_APIC]}};
endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
  parameter int unsigned N_CPU      = 6,
  parameter int unsigned N_MID      = 2,
  parameter int unsigned N_PCI      = 5,
  parameter int unsigned N_APIC     = 3,
  parameter int unsigned SETTLE_CYC = 32
) (
  input logic              clk_cpu,
  input logic              clk_mid,
  input logic              clk_pci,
  input logic              clk_ref,
  input logic              clk_apic,
  input logic              rst,
  input logic              cpu_stop_n,
  input logic              pci_stop_n,
  input logic [N_CPU-1:0]  cpu_clk_o,
  input logic [N_MID-1:0]  mid_clk_o,
  input logic [N_PCI-1:0]  pci_clk_o,
  input logic              pcif_clk_o,
  input logic [N_APIC-1:0] apic_clk_o,
  input logic              osc_en,
  input logic              pll_en,
  input logic              ready
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_ref) begin
    if (rst || !osc_en)          hi_cnt <= 0;
    else if (hi_cnt < SETTLE_CYC) hi_cnt <= hi_cnt + 1;
  end

  // R2
  cpu_park_chk: assert property (@(negedge clk_cpu) disable iff (rst)
    (!cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2) && $past(!cpu_stop_n, 3))
    |-> (cpu_clk_o == '0));

  // R7
  mid_park_chk: assert property (@(negedge clk_mid) disable iff (rst)
    (!cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2) && $past(!cpu_stop_n, 3))
    |-> (mid_clk_o == '0));

  // R3
  pci_park_chk: assert property (@(negedge clk_pci) disable iff (rst)
    (!pci_stop_n && $past(!pci_stop_n) && $past(!pci_stop_n, 2) && $past(!pci_stop_n, 3))
    |-> (pci_clk_o == '0));

  // R1
  apic_pd_chk: assert property (@(negedge clk_apic) disable iff (rst)
    (!ready && $past(!ready) && $past(!ready, 2) && $past(!ready, 3))
    |-> (apic_clk_o == '0));

  // R1
  pcif_pd_chk: assert property (@(negedge clk_pci) disable iff (rst)
    (!ready && $past(!ready) && $past(!ready, 2) && $past(!ready, 3))
    |-> (pcif_clk_o == 1'b0));

  // R1
  pd_clear_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(osc_en) |-> !ready);

  // R9
  pll_order_chk: assert property (@(posedge clk_ref) disable iff (rst)
    pll_en |-> osc_en);

  // R4
  ready_en_chk: assert property (@(posedge clk_ref) disable iff (rst)
    ready |-> (osc_en && pll_en));

  // R8
  settle_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(ready) |-> (hi_cnt >= SETTLE_CYC));
endmodule

bind clkstop_ctrl cg_chk #(
  .N_CPU      (N_CPU),
  .N_MID      (N_MID),
  .N_PCI      (N_PCI),
  .N_APIC     (N_APIC),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk_cpu    (clk_cpu),
  .clk_mid    (clk_mid),
  .clk_pci    (clk_pci),
  .clk_ref    (clk_ref),
  .clk_apic   (clk_apic),
  .rst        (rst),
  .cpu_stop_n (cpu_stop_n),
  .pci_stop_n (pci_stop_n),
  .cpu_clk_o  (cpu_clk_o),
  .mid_clk_o  (mid_clk_o),
  .pci_clk_o  (pci_clk_o),
  .pcif_clk_o (pcif_clk_o),
  .apic_clk_o (apic_clk_o),
  .osc_en     (osc_en),
  .pll_en     (pll_en),
  .ready      (ready)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/100ps

module sim_pulse_mon #(
  parameter int    HALF = 10,
  parameter int    W    = 1,
  parameter string NAME = "grp"
) (
  input logic         clk,
  input logic         arm,
  input logic [W-1:0] g
);
  int chk_hi = 0;
  int chk_lo = 0;
  int fail_hi = 0;
  int fail_lo = 0;
  logic [W-1:0] a;

  // R6 / R11: a high phase is all-on or all-off, identical across copies
  always @(posedge clk) begin
    if (arm) begin
      #1 a = g;
      #(HALF - 2);
      chk_hi++;
      if (g !== a || !(a == '0 || a == '1)) begin
        fail_hi++;
        $display("FAIL R6 R11 %s high phase: start=%b end=%b expected equal whole-group value", NAME, a, g);
      end
    end
  end

  // R6: low phase of the source clock must be LOW on the output
  always @(negedge clk) begin
    if (arm) begin
      #1;
      chk_lo++;
      if (g !== '0) begin
        fail_lo++;
        $display("FAIL R6 %s low phase: actual=%b expected=0", NAME, g);
      end
    end
  end
endmodule

module sim_clkstop_ctrl;
  localparam int S = 12;

  logic clk_cpu = 0, clk_mid = 0, clk_pci = 0, clk_ref = 0, clk_apic = 0;
  always #10 clk_cpu  = ~clk_cpu;
  always #15 clk_mid  = ~clk_mid;
  always #30 clk_pci  = ~clk_pci;
  always #35 clk_ref  = ~clk_ref;
  always #60 clk_apic = ~clk_apic;

  logic rst = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1, arm = 1'b0;
  logic [5:0] cpu_clk_o;
  logic [1:0] mid_clk_o;
  logic [4:0] pci_clk_o;
  logic       pcif_clk_o;
  logic [1:0] ref_clk_o;
  logic [2:0] apic_clk_o;
  logic       osc_en, pll_en;

  clkstop_ctrl #(.SETTLE_CYC(S)) u0 (
    .clk_cpu(clk_cpu), .clk_mid(clk_mid), .clk_pci(clk_pci), .clk_ref(clk_ref),
    .clk_apic(clk_apic), .rst(rst), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwrdn_n(pwrdn_n), .cpu_clk_o(cpu_clk_o), .mid_clk_o(mid_clk_o), .pci_clk_o(pci_clk_o),
    .pcif_clk_o(pcif_clk_o), .ref_clk_o(ref_clk_o), .apic_clk_o(apic_clk_o),
    .osc_en(osc_en), .pll_en(pll_en)
  );

  sim_pulse_mon #(.HALF(10), .W(6), .NAME("cpu"))  m_cpu  (.clk(clk_cpu),  .arm(arm), .g(cpu_clk_o));
  sim_pulse_mon #(.HALF(15), .W(2), .NAME("mid"))  m_mid  (.clk(clk_mid),  .arm(arm), .g(mid_clk_o));
  sim_pulse_mon #(.HALF(30), .W(5), .NAME("pci"))  m_pci  (.clk(clk_pci),  .arm(arm), .g(pci_clk_o));
  sim_pulse_mon #(.HALF(30), .W(1), .NAME("pcif")) m_pcif (.clk(clk_pci),  .arm(arm), .g(pcif_clk_o));
  sim_pulse_mon #(.HALF(35), .W(2), .NAME("ref"))  m_ref  (.clk(clk_ref),  .arm(arm), .g(ref_clk_o));
  sim_pulse_mon #(.HALF(60), .W(3), .NAME("apic")) m_apic (.clk(clk_apic), .arm(arm), .g(apic_clk_o));

  int n_cpu = 0, n_mid = 0, n_pci = 0, n_pcif = 0, n_ref = 0, n_apic = 0;
  always @(posedge cpu_clk_o[0])  n_cpu++;
  always @(posedge mid_clk_o[0])  n_mid++;
  always @(posedge pci_clk_o[0])  n_pci++;
  always @(posedge pcif_clk_o)    n_pcif++;
  always @(posedge ref_clk_o[0])  n_ref++;
  always @(posedge apic_clk_o[0]) n_apic++;

  int checks = 0;
  int failures = 0;
  int base[6];
  string gname[6] = '{"cpu", "mid", "pci", "pcif", "ref", "apic"};

  function automatic int cnt_of(input int i);
    case (i)
      0: return n_cpu;
      1: return n_mid;
      2: return n_pci;
      3: return n_pcif;
      4: return n_ref;
      default: return n_apic;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic snap_all();
    for (int i = 0; i < 6; i++) base[i] = cnt_of(i);
  endtask

  task automatic sweep_point(input bit p, input bit c, input bit q);
    int b[6];
    bit exp_run;
    string req;
    pwrdn_n = p; cpu_stop_n = c; pci_stop_n = q;
    #2000.5;
    for (int i = 0; i < 6; i++) b[i] = cnt_of(i);
    #1200;
    for (int i = 0; i < 6; i++) begin
      if (i <= 1)      exp_run = p & c;
      else if (i == 2) exp_run = p & q;
      else             exp_run = p;
      if (!p)                    req = "R1";
      else if (i == 2 || i == 3) req = "R3";
      else                       req = "R2";
      chk(req, $sformatf("%s running p=%0d c=%0d q=%0d", gname[i], p, c, q),
          int'((cnt_of(i) - b[i]) > 0), int'(exp_run));
    end
    chk(p ? "R4" : "R1", "osc_en", int'(osc_en), int'(p));
    chk(p ? "R4" : "R1", "pll_en", int'(pll_en), int'(p));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0;
    // R10: reset state
    #200;
    snap_all();
    #280;
    for (int i = 0; i < 6; i++)
      chk("R10", {gname[i], " pulses in reset"}, cnt_of(i) - base[i], 0);
    chk("R10", "osc_en in reset", int'(osc_en), 0);
    chk("R10", "pll_en in reset", int'(pll_en), 0);
    #20.5 rst = 1'b0;
    arm = 1'b1;

    sweep_point(1'b1, 1'b1, 1'b1);

    // R5: processor stop and start latency
    @(posedge clk_cpu); #1 cpu_stop_n = 1'b0;
    d0 = n_cpu;
    repeat (2) @(posedge clk_cpu);
    #2 chk("R5", "cpu pulses after stop", n_cpu - d0, 2);
    repeat (4) @(posedge clk_cpu);
    #2 chk("R5", "cpu pulses after stop settled", n_cpu - d0, 2);
    @(posedge clk_cpu); #1 cpu_stop_n = 1'b1;
    d0 = n_cpu;
    repeat (2) @(posedge clk_cpu);
    #2 chk("R5", "cpu pulses before third edge", n_cpu - d0, 0);
    @(posedge clk_cpu);
    #2 chk("R5", "cpu pulse on third edge", n_cpu - d0, 1);

    // R7: 66 MHz group through its own synchronizer
    @(posedge clk_mid); #1 cpu_stop_n = 1'b0;
    d0 = n_mid;
    repeat (3) @(posedge clk_mid);
    #2 chk("R7", "mid pulses within 3 cycles", n_mid - d0, 2);
    repeat (4) @(posedge clk_mid);
    #2 chk("R7", "mid pulses after stop settled", n_mid - d0, 2);
    cpu_stop_n = 1'b1;
    #500;

    // R3: bus stop latency and free-running exemption
    @(posedge clk_pci); #1 pci_stop_n = 1'b0;
    d0 = n_pci; base[3] = n_pcif;
    repeat (3) @(posedge clk_pci);
    #2 chk("R3", "pci pulses after stop", n_pci - d0, 2);
    chk("R3", "pcif pulses during stop", n_pcif - base[3], 3);
    repeat (4) @(posedge clk_pci);
    #2 chk("R3", "pci pulses after stop settled", n_pci - d0, 2);
    pci_stop_n = 1'b1;
    #500;

    // R9: power-down enable timeline
    @(posedge clk_ref); #1 pwrdn_n = 1'b0;
    @(posedge clk_ref);
    @(posedge clk_ref); #2;
    chk("R9", "osc_en after 2nd edge of power down", int'(osc_en), 1);
    chk("R9", "pll_en after 2nd edge of power down", int'(pll_en), 1);
    @(posedge clk_ref); #2;
    chk("R9", "osc_en after 3rd edge of power down", int'(osc_en), 0);
    chk("R9", "pll_en after 3rd edge of power down", int'(pll_en), 0);
    #1500;

    // R8 / R9: power-up settle timeline
    @(posedge clk_ref); #1 pwrdn_n = 1'b1;
    snap_all();
    @(posedge clk_ref);
    @(posedge clk_ref); #2;
    chk("R9", "osc_en after 2nd edge of power up", int'(osc_en), 0);
    @(posedge clk_ref); #2;
    chk("R9", "osc_en after 3rd edge of power up", int'(osc_en), 1);
    chk("R9", "pll_en after 3rd edge of power up", int'(pll_en), 0);
    @(posedge clk_ref); #2;
    chk("R9", "pll_en after 4th edge of power up", int'(pll_en), 1);
    repeat (S - 1) @(posedge clk_ref);
    #2;
    for (int i = 0; i < 6; i++)
      chk("R8", {gname[i], " pulses during settle"}, cnt_of(i) - base[i], 0);
    repeat (2) @(posedge clk_ref);
    #2 chk("R8", "ref pulses through edge S+5", n_ref - base[4], 0);
    @(posedge clk_ref);
    #2 chk("R8", "ref pulses on edge S+6", n_ref - base[4], 1);

    // Sweep all request combinations, binary then reflected Gray order
    for (int k = 0; k < 8; k++)
      sweep_point(k[2], k[1], k[0]);
    for (int k = 7; k >= 0; k--) begin
      int gk;
      gk = k ^ (k >> 1);
      sweep_point(gk[2], gk[1], gk[0]);
    end

    // R6: random asynchronous request edges, whole-phase monitors active
    for (int n = 0; n < 150; n++) begin
      int sel;
      #0.5;
      #($urandom_range(30, 700));
      sel = $urandom_range(0, 2);
      case (sel)
        0: cpu_stop_n = ~cpu_stop_n;
        1: pci_stop_n = ~pci_stop_n;
        default: pwrdn_n = ~pwrdn_n;
      endcase
    end
    sweep_point(1'b1, 1'b0, 1'b1);
    sweep_point(1'b1, 1'b1, 1'b1);

    arm = 1'b0;
    #200;
    checks   += m_cpu.chk_hi + m_cpu.chk_lo + m_mid.chk_hi + m_mid.chk_lo
              + m_pci.chk_hi + m_pci.chk_lo + m_pcif.chk_hi + m_pcif.chk_lo
              + m_ref.chk_hi + m_ref.chk_lo + m_apic.chk_hi + m_apic.chk_lo;
    failures += m_cpu.fail_hi + m_cpu.fail_lo + m_mid.fail_hi + m_mid.fail_lo
              + m_pci.fail_hi + m_pci.fail_lo + m_pcif.fail_hi + m_pcif.fail_lo
              + m_ref.fail_hi + m_ref.fail_lo + m_apic.fail_hi + m_apic.fail_lo;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule